// File: doc/BRIEF.md
# Sequential Carry-Save Multiplier

This block multiplies two unsigned operands of `WIDTH` bits, 8 by default, over several clock cycles and returns a product of twice that width. It uses the shift-and-add method with right shifts. Each cycle it looks at one bit of the multiplier operand, starting from the least significant bit. If that bit is 1 it adds the multiplicand into a running partial product. The partial product is never collapsed into a single binary number while the loop runs. It is kept as two vectors, a sum vector and a carry vector. A row of independent full adders combines these two vectors with the gated multiplicand, so a step costs one full-adder level and has no carry chain.

In each step the lowest bit of the full-adder row is final. That bit is shifted into the low half of the product. The remaining sum bits move down one place, and the carry bits, which already weigh one place more, take their place as the next carry vector. After `WIDTH` steps a single carry-propagate addition merges the two vectors into the upper half of the product.

A request enters through a valid/ready handshake. `in_ready` is high only while the block is idle, and a request is taken on a clock edge where both `in_valid` and `in_ready` are high. While a multiplication is running, `in_ready` stays low. Any request presented during that time is not captured, and the requester must hold it until `in_ready` returns. The result side has no back-pressure. `done_o` pulses for one cycle, and `product_o` keeps its value until the next result replaces it.

Top module: `csa_seq_mult`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released, `in_ready` is 1, `done_o` is 0 and `product_o` is 0.
- R2: A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the cycle in which `done_o` is 1.
- R3: While `in_ready` is 0, `in_valid` and the operand inputs have no effect. The product that is delivered belongs to the operands captured at acceptance.
- R4: `product_o` equals the unsigned product `a_i * x_i` of the accepted operands, as a 2*WIDTH-bit value. For example, 101 × 172 gives 17372 and 97 × 108 gives 10476.
- R5: `done_o` is 1 for exactly one cycle, starting WIDTH+1 rising edges after the accepting edge.
- R6: Between results, `product_o` holds the last delivered product.
- R7: Corner operands give exact products: zero, 255 (all ones) and single-bit powers of two.
- R8: `in_ready` is 1 in the cycle where `done_o` is 1, so a new request can be accepted on the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request with operands is presented |
| in_ready | output | 1 | Block is idle and will take a request |
| a_i | input | WIDTH | Multiplicand, unsigned |
| x_i | input | WIDTH | Multiplier, unsigned; its bits are consumed LSB first |
| done_o | output | 1 | One-cycle pulse when `product_o` is updated |
| product_o | output | 2*WIDTH | Most recent product |

## Verification
The multiply path is tested with the two fixed pairs from R4 and with zero and all-ones operands. Zero operands show whether an empty partial product leaks stray carries. The all-ones pair 255 × 255 drives the most carry traffic through every step and into the final addition. Single-bit powers of two place one partial product at a known step and so expose misaligned carry or retire positions. Random operands cover general bit mixes. Two further sequences test the handshake: one holds `in_valid` high with different operands while the block is busy, which separates ignoring a request from re-capturing operands, and one sends requests back to back to exercise the done-cycle accept.

// File: rtl/csm_pkg.sv
package csm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } csm_state_e;
endpackage

// File: rtl/csm_ctrl.sv
module csm_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic fin,
  output logic done
);
  import csm_pkg::*;

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  csm_state_e state_q;
  logic [CW-1:0] cnt_q;

  assign in_ready = (state_q == ST_IDLE);
  assign load     = in_valid && in_ready;
  assign step     = (state_q == ST_RUN);
  assign fin      = (state_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= fin;
      unique case (state_q)
        ST_IDLE: if (load) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == LAST) state_q <= ST_FIN;
          cnt_q <= cnt_q + 1'b1;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready); // R8
endmodule

// File: rtl/csm_csa_step.sv
module csm_csa_step #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] x_in,
  output logic [WIDTH-1:0] sum_q,
  output logic [WIDTH-1:0] carry_q,
  output logic [WIDTH-1:0] low_q
);
  logic [WIDTH-1:0] a_q, x_q;
  logic [WIDTH-1:0] pp, fa_s, fa_c;

  // one full adder per bit position: no carry travels between columns
  for (genvar i = 0; i < WIDTH; i++) begin : g_col
    assign pp[i]   = a_q[i] & x_q[0];
    assign fa_s[i] = sum_q[i] ^ carry_q[i] ^ pp[i];
    assign fa_c[i] = (sum_q[i] & carry_q[i]) | (sum_q[i] & pp[i]) | (carry_q[i] & pp[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      x_q     <= '0;
      sum_q   <= '0;
      carry_q <= '0;
      low_q   <= '0;
    end else if (load) begin
      a_q     <= a_in;
      x_q     <= x_in;
      sum_q   <= '0;
      carry_q <= '0;
      low_q   <= '0;
    end else if (step) begin
      // bit 0 is final: retire it; carries already weigh one place up
      low_q   <= {fa_s[0], low_q[WIDTH-1:1]};
      sum_q   <= {1'b0, fa_s[WIDTH-1:1]};
      carry_q <= fa_c;
      x_q     <= {1'b0, x_q[WIDTH-1:1]};
    end
  end

  AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && step)); // R3
  AST_OPERAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(a_q)); // R3
endmodule

// File: rtl/csm_final_add.sv
module csm_final_add #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fin,
  input  logic [WIDTH-1:0]   sum_in,
  input  logic [WIDTH-1:0]   carry_in,
  input  logic [WIDTH-1:0]   low_in,
  output logic [2*WIDTH-1:0] product_q
);
  logic [WIDTH:0] merged;

  assign merged = {1'b0, sum_in} + {1'b0, carry_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   product_q <= '0;
    else if (fin) product_q <= {merged[WIDTH-1:0], low_in};
  end

  AST_NO_TOP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !merged[WIDTH]); // R4
endmodule

// File: rtl/csa_seq_mult.sv
module csa_seq_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   x_i,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic load, step, fin;
  logic [WIDTH-1:0] sum_v, carry_v, low_v;

  csm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .load(load), .step(step), .fin(fin), .done(done_o)
  );

  csm_csa_step #(.WIDTH(WIDTH)) u_step (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .a_in(a_i), .x_in(x_i),
    .sum_q(sum_v), .carry_q(carry_v), .low_q(low_v)
  );

  csm_final_add #(.WIDTH(WIDTH)) u_fin (
    .clk(clk), .rst_n(rst_n), .fin(fin),
    .sum_in(sum_v), .carry_in(carry_v), .low_in(low_v),
    .product_q(product_o)
  );

  AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(product_o)); // R6
endmodule

// File: tb/csa_seq_mult_tb.sv
module csa_seq_mult_tb;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] a_i = '0, x_i = '0;
  logic done_o;
  logic [2*W-1:0] product_o;

  int tests = 0;
  int fails = 0;
  string cur_req = "R4";

  // reference model state
  int busy_left = 0;
  logic exp_done = 1'b0;
  logic [2*W-1:0] exp_prod = '0;
  logic [2*W-1:0] pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_seq_mult #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_i(a_i), .x_i(x_i), .done_o(done_o), .product_o(product_o)
  );

  task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle model: accept when idle, result W+1 edges later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_left = 0;
      exp_done  = 1'b0;
      exp_prod  = '0;
    end else begin
      exp_done = 1'b0;
      if (busy_left == 0) begin
        if (in_valid) begin
          busy_left = W + 1;
          pend = (2*W)'(a_i) * (2*W)'(x_i);
        end
      end else begin
        busy_left--;
        if (busy_left == 0) begin
          exp_done = 1'b1;
          exp_prod = pend;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 ready", {15'd0, in_ready}, {15'd0, busy_left == 0});
      check("R5 done", {15'd0, done_o}, {15'd0, exp_done});
      check({cur_req, " product"}, product_o, exp_prod);
    end
  end

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] x);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; a_i = a; x_i = x;
    @(negedge clk);
    in_valid = 1'b0;
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    check("R1 ready", {15'd0, in_ready}, 16'd1);
    check("R1 done", {15'd0, done_o}, 16'd0);
    check("R1 product", product_o, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after", {15'd0, in_ready}, 16'd1);
    check("R1 product after", product_o, 16'd0);

    cur_req = "R4";
    issue(8'd101, 8'd172);
    check("R4 101x172", product_o, 16'd17372);
    issue(8'd97, 8'd108);
    check("R4 97x108", product_o, 16'd10476);

    cur_req = "R7";
    issue(8'd0, 8'd0);     check("R7 0x0", product_o, 16'd0);
    issue(8'd0, 8'd255);   check("R7 0x255", product_o, 16'd0);
    issue(8'd255, 8'd0);   check("R7 255x0", product_o, 16'd0);
    issue(8'd255, 8'd255); check("R7 255x255", product_o, 16'd65025);
    for (int i = 0; i < W; i++) begin
      issue(8'(1 << i), 8'd255);
      check("R7 pow2 a", product_o, 16'(255 << i));
      issue(8'd173, 8'(1 << i));
      check("R7 pow2 x", product_o, 16'(173 << i));
    end

    // R3: keep presenting other operands while busy
    cur_req = "R3";
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; a_i = 8'd13; x_i = 8'd11;
    @(negedge clk);
    for (int k = 0; k < W - 1; k++) begin
      a_i = 8'(200 + k); x_i = 8'(77 + k);
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (!done_o) @(negedge clk);
    check("R3 ignored", product_o, 16'd143);

    // R6: idle gap, product must stay
    cur_req = "R6";
    repeat (6) @(negedge clk);
    check("R6 held", product_o, 16'd143);

    // R8 back-to-back plus random operands
    cur_req = "R8";
    for (int n = 0; n < 150; n++) begin
      logic [W-1:0] ra, rx;
      ra = W'($urandom);
      rx = W'($urandom);
      issue(ra, rx);
      check("R8 random", product_o, 16'(ra) * 16'(rx));
    end

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule